// File: doc/BRIEF.md
# Bus-Matching FIFO with Selectable Byte Order

This block is a single-clock first-in first-out buffer whose write side and read side are each either one 18-bit word or one 9-bit byte wide. The two widths are chosen independently. When a wide word is read out on a narrow port it leaves as two bytes. When bytes enter a narrow write port and leave on a wide read port they are packed in pairs. A byte-order setting decides which half of a wide word is the first byte in that sequence.

The widths and the byte order are captured from three configuration inputs on every clock edge while master reset is held low, and are frozen after that. Master reset empties the buffer, clears the storage and loads a new configuration. Partial reset empties the buffer but keeps the configuration. Storage is counted in 9-bit units. Empty, full and half-full are judged against the needs of the wider port. The read port shows its head word ahead of the read strobe: `rd_data` is valid whenever `empty` is low, and a read strobe removes that word at the next clock edge.

Top module: `busmatch_fifo`

## Requirements
- R1: `cfg_wr_narrow` = 0 selects an 18-bit write word and 1 selects a 9-bit write byte taken from `wr_data[8:0]`. `cfg_rd_narrow` = 0 selects an 18-bit read word and 1 selects a 9-bit read byte. All four combinations move data in FIFO order.
- R2: With `cfg_big_end` = 1, an 18-bit word read on a 9-bit port leaves as bits [17:9] first and bits [8:0] second.
- R3: With `cfg_big_end` = 0, an 18-bit word read on a 9-bit port leaves as bits [8:0] first and bits [17:9] second.
- R4: With a 9-bit write and an 18-bit read, the earlier byte of a pair lands in [17:9] when `cfg_big_end` = 1 and in [8:0] when `cfg_big_end` = 0.
- R5: The configuration inputs are sampled only on clock edges at which `mrst_n` is low. Later changes on them have no effect.
- R6: Master reset (`mrst_n` low, synchronous) empties the buffer. The next cycle shows `empty` = 1, `full` = 0 and `half_full` = 0.
- R7: Partial reset (`prst_n` low, synchronous) empties the buffer and keeps the configuration latched at the last master reset.
- R8: `empty` is 1 while fewer 9-bit units are held than one read takes (1 or 2). A read strobe is then ignored.
- R9: `full` is 1 while fewer 9-bit units are free than one write needs (1 or 2). A write strobe is then ignored and the stored data is unchanged.
- R10: `half_full` is 1 exactly when more than DEPTH/2 units are held.
- R11: When `empty` is 0, `rd_data` shows the head word. On a 9-bit read port, `rd_data[17:9]` is zero.
- R12: A write and a read accepted in the same cycle both take effect. Occupancy changes by the write size minus the read size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| mrst_n | input | 1 | Master reset, active low, synchronous; loads configuration |
| prst_n | input | 1 | Partial reset, active low, synchronous; keeps configuration |
| cfg_wr_narrow | input | 1 | Write width select, sampled in master reset (1 = 9 bit) |
| cfg_rd_narrow | input | 1 | Read width select, sampled in master reset (1 = 9 bit) |
| cfg_big_end | input | 1 | Byte order select, sampled in master reset (1 = high half first) |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 18 | Write data; only [8:0] is used in 9-bit write mode |
| rd_en | input | 1 | Read strobe; removes the word shown on rd_data |
| rd_data | output | 18 | Head word, valid while empty is low |
| empty | output | 1 | Not enough units for one read |
| full | output | 1 | Not enough room for one write |
| half_full | output | 1 | More than half the units occupied |

## Verification
The hardest states to reach are those where the odd unit count leaves the flags mismatched. One case is a single free unit with an 18-bit write port: `full` must stay high. The other is a single held byte with an 18-bit read port: `empty` must stay high. The first is reached by filling the buffer with wide words and then removing one byte through a narrow read. The second is reached by writing one byte in 9-bit write mode and checking before its partner arrives. All eight mode combinations are then run through fill, drain and random mixed traffic, and each cycle is compared against a byte queue model.

// File: rtl/bmf_pkg.sv
package bmf_pkg;
   typedef struct packed {
      logic wr_narrow;
      logic rd_narrow;
      logic big_end;
   } bmf_cfg_t;
endpackage

// File: rtl/bmf_cfg_reg.sv
module bmf_cfg_reg
   import bmf_pkg::*;
(
   input  logic     clk,
   input  logic     mrst_n,
   input  bmf_cfg_t cfg_d,
   output bmf_cfg_t cfg_q
);
   // Settings load only while master reset is held
   always_ff @(posedge clk) begin
      if (!mrst_n) cfg_q <= cfg_d;
   end

   p_cfg_hold_r5: assert property (@(posedge clk) disable iff (!mrst_n)
      1'b1 |=> $stable(cfg_q))
      else $error("R5: configuration changed outside master reset");
endmodule

// File: rtl/bmf_ptr_ctrl.sv
module bmf_ptr_ctrl
   import bmf_pkg::*;
#(
   parameter int DEPTH = 32,
   localparam int PW = $clog2(DEPTH),
   localparam int CW = PW + 1
) (
   input  logic          clk,
   input  logic          mrst_n,
   input  logic          prst_n,
   input  bmf_cfg_t      cfg,
   input  logic          wr_en,
   input  logic          rd_en,
   output logic [PW-1:0] wr_ptr,
   output logic [PW-1:0] rd_ptr,
   output logic          wr_go,
   output logic          rd_go,
   output logic          empty,
   output logic          full,
   output logic          half_full
);
   localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
   localparam logic [CW-1:0] HALF_C  = CW'(DEPTH / 2);

   logic [CW-1:0] cnt;
   logic [CW-1:0] wr_units, rd_units, room;

   assign wr_units  = cfg.wr_narrow ? CW'(1) : CW'(2);
   assign rd_units  = cfg.rd_narrow ? CW'(1) : CW'(2);
   assign room      = DEPTH_C - cnt;
   assign full      = room < wr_units;
   assign empty     = cnt < rd_units;
   assign half_full = cnt > HALF_C;
   assign wr_go     = wr_en && !full;
   assign rd_go     = rd_en && !empty;

   always_ff @(posedge clk) begin
      if (!mrst_n || !prst_n) begin
         cnt    <= '0;
         wr_ptr <= '0;
         rd_ptr <= '0;
      end else begin
         if (wr_go) wr_ptr <= wr_ptr + PW'(wr_units);
         if (rd_go) rd_ptr <= rd_ptr + PW'(rd_units);
         cnt <= cnt + (wr_go ? wr_units : '0) - (rd_go ? rd_units : '0);
      end
   end

   p_no_overflow_r9: assert property (@(posedge clk) disable iff (!mrst_n)
      cnt <= DEPTH_C)
      else $error("R9: occupancy beyond storage");
   p_full_blocks_r9: assert property (@(posedge clk) disable iff (!mrst_n)
      (full && wr_en && prst_n) |=> wr_ptr == $past(wr_ptr))
      else $error("R9: write accepted while full");
   p_empty_blocks_r8: assert property (@(posedge clk) disable iff (!mrst_n)
      (empty && rd_en && prst_n) |=> rd_ptr == $past(rd_ptr))
      else $error("R8: read accepted while empty");
   p_prst_clears_r7: assert property (@(posedge clk) disable iff (!mrst_n)
      !prst_n |=> (cnt == '0) && (wr_ptr == rd_ptr))
      else $error("R7: partial reset left data");
   p_half_not_empty_r10: assert property (@(posedge clk) disable iff (!mrst_n)
      half_full |-> !empty)
      else $error("R10: half full while empty");
endmodule

// File: rtl/bmf_store.sv
module bmf_store #(
   parameter int UNIT_W = 9,
   parameter int DEPTH  = 32,
   localparam int PW = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              clr,
   input  logic              wr_go,
   input  logic              wr_two,
   input  logic [PW-1:0]     wr_ptr,
   input  logic [UNIT_W-1:0] wu0,
   input  logic [UNIT_W-1:0] wu1,
   input  logic [PW-1:0]     rd_ptr,
   output logic [UNIT_W-1:0] ru0,
   output logic [UNIT_W-1:0] ru1
);
   logic [UNIT_W-1:0] mem [DEPTH];
   logic [PW-1:0]     wr_nxt, rd_nxt;
   logic [DEPTH-1:0]  hit0, hit1;

   assign wr_nxt = wr_ptr + PW'(1);
   assign rd_nxt = rd_ptr + PW'(1);

   for (genvar g = 0; g < DEPTH; g++) begin : g_loc
      assign hit0[g] = wr_go && (wr_ptr == PW'(g));
      assign hit1[g] = wr_go && wr_two && (wr_nxt == PW'(g));
   end

   always_ff @(posedge clk) begin
      for (int i = 0; i < DEPTH; i++) begin
         if (clr)          mem[i] <= '0;
         else if (hit0[i]) mem[i] <= wu0;
         else if (hit1[i]) mem[i] <= wu1;
      end
   end

   assign ru0 = mem[rd_ptr];
   assign ru1 = mem[rd_nxt];

   p_one_slot_r1: assert property (@(posedge clk) disable iff (clr)
      $countones(hit0) <= 1 && $countones(hit1) <= 1)
      else $error("R1: write decoded to several locations");
endmodule

// File: rtl/bmf_lane_map.sv
module bmf_lane_map
   import bmf_pkg::*;
#(
   parameter int UNIT_W = 9,
   localparam int WORD_W = 2 * UNIT_W
) (
   input  bmf_cfg_t          cfg,
   input  logic [WORD_W-1:0] wr_data,
   input  logic [UNIT_W-1:0] ru0,
   input  logic [UNIT_W-1:0] ru1,
   output logic [UNIT_W-1:0] wu0,
   output logic [UNIT_W-1:0] wu1,
   output logic [WORD_W-1:0] rd_data
);
   logic [UNIT_W-1:0] hi_in, lo_in;

   assign hi_in = wr_data[WORD_W-1:UNIT_W];
   assign lo_in = wr_data[UNIT_W-1:0];

   // Unit 0 is always the one that leaves first
   always_comb begin
      if (cfg.wr_narrow) begin
         wu0 = lo_in;
         wu1 = '0;
      end else if (cfg.big_end) begin
         wu0 = hi_in;
         wu1 = lo_in;
      end else begin
         wu0 = lo_in;
         wu1 = hi_in;
      end

      if (cfg.rd_narrow)    rd_data = {{UNIT_W{1'b0}}, ru0};
      else if (cfg.big_end) rd_data = {ru0, ru1};
      else                  rd_data = {ru1, ru0};
   end
endmodule

// File: rtl/busmatch_fifo.sv
module busmatch_fifo
   import bmf_pkg::*;
#(
   parameter int UNIT_W = 9,
   parameter int DEPTH  = 32,
   localparam int WORD_W = 2 * UNIT_W,
   localparam int PW = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              mrst_n,
   input  logic              prst_n,
   input  logic              cfg_wr_narrow,
   input  logic              cfg_rd_narrow,
   input  logic              cfg_big_end,
   input  logic              wr_en,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              rd_en,
   output logic [WORD_W-1:0] rd_data,
   output logic              empty,
   output logic              full,
   output logic              half_full
);
   if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 4");
   end
   if (UNIT_W < 1) begin : g_bad_unit
      $error("UNIT_W must be positive");
   end

   bmf_cfg_t          cfg_pins, cfg;
   logic [PW-1:0]     wr_ptr, rd_ptr;
   logic              wr_go, rd_go;
   logic [UNIT_W-1:0] wu0, wu1, ru0, ru1;

   assign cfg_pins = '{wr_narrow: cfg_wr_narrow, rd_narrow: cfg_rd_narrow,
                       big_end: cfg_big_end};

   bmf_cfg_reg u_cfg (
      .clk   (clk),
      .mrst_n(mrst_n),
      .cfg_d (cfg_pins),
      .cfg_q (cfg)
   );

   bmf_ptr_ctrl #(.DEPTH(DEPTH)) u_ctrl (
      .clk      (clk),
      .mrst_n   (mrst_n),
      .prst_n   (prst_n),
      .cfg      (cfg),
      .wr_en    (wr_en),
      .rd_en    (rd_en),
      .wr_ptr   (wr_ptr),
      .rd_ptr   (rd_ptr),
      .wr_go    (wr_go),
      .rd_go    (rd_go),
      .empty    (empty),
      .full     (full),
      .half_full(half_full)
   );

   bmf_lane_map #(.UNIT_W(UNIT_W)) u_map (
      .cfg    (cfg),
      .wr_data(wr_data),
      .ru0    (ru0),
      .ru1    (ru1),
      .wu0    (wu0),
      .wu1    (wu1),
      .rd_data(rd_data)
   );

   bmf_store #(.UNIT_W(UNIT_W), .DEPTH(DEPTH)) u_store (
      .clk   (clk),
      .clr   (!mrst_n),
      .wr_go (wr_go),
      .wr_two(!cfg.wr_narrow),
      .wr_ptr(wr_ptr),
      .wu0   (wu0),
      .wu1   (wu1),
      .rd_ptr(rd_ptr),
      .ru0   (ru0),
      .ru1   (ru1)
   );

   p_narrow_upper_zero_r11: assert property (@(posedge clk) disable iff (!mrst_n)
      (cfg.rd_narrow && !empty) |-> rd_data[WORD_W-1:UNIT_W] == '0)
      else $error("R11: upper byte set on narrow read");
   p_mrst_empties_r6: assert property (@(posedge clk)
      !mrst_n |=> empty && !full && !half_full)
      else $error("R6: master reset did not empty");
endmodule

// File: tb/busmatch_fifo_test.sv
module busmatch_fifo_test;
   localparam int CLK_NS = 10;
   localparam int DEPTH  = 32;

   logic        clk = 1'b0;
   logic        mrst_n = 1'b0, prst_n = 1'b1;
   logic        cfg_wr_narrow = 1'b0, cfg_rd_narrow = 1'b0, cfg_big_end = 1'b0;
   logic        wr_en = 1'b0, rd_en = 1'b0;
   logic [17:0] wr_data = '0;
   logic [17:0] rd_data;
   logic        empty, full, half_full;

   int   errors = 0, checks = 0;
   bit   done = 1'b0;
   logic [8:0] q[$];
   bit   m_wn, m_rn, m_be;

   always #(CLK_NS / 2) clk = ~clk;

   busmatch_fifo #(.UNIT_W(9), .DEPTH(DEPTH)) uut (
      .clk(clk), .mrst_n(mrst_n), .prst_n(prst_n),
      .cfg_wr_narrow(cfg_wr_narrow), .cfg_rd_narrow(cfg_rd_narrow),
      .cfg_big_end(cfg_big_end), .wr_en(wr_en), .wr_data(wr_data),
      .rd_en(rd_en), .rd_data(rd_data), .empty(empty), .full(full),
      .half_full(half_full)
   );

   task automatic chk(bit ok, string tag, logic [17:0] act, logic [17:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic bit m_empty();
      return q.size() < (m_rn ? 1 : 2);
   endfunction
   function automatic bit m_full();
      return (DEPTH - q.size()) < (m_wn ? 1 : 2);
   endfunction
   function automatic logic [17:0] m_head();
      if (m_rn) return {9'd0, q[0]};
      return m_be ? {q[0], q[1]} : {q[1], q[0]};
   endfunction

   // Compare all outputs against the model at the current negedge
   task automatic compare(string ptag);
      string dtag;
      chk(empty == m_empty(), {ptag, " R8 empty"}, 18'(empty), 18'(m_empty()));
      chk(full == m_full(), {ptag, " R9 full"}, 18'(full), 18'(m_full()));
      chk(half_full == (q.size() > DEPTH / 2), {ptag, " R10 half_full"},
          18'(half_full), 18'(q.size() > DEPTH / 2));
      if (!m_empty()) begin
         if (!m_wn && m_rn) dtag = m_be ? "R2" : "R3";
         else if (m_wn && !m_rn) dtag = "R4";
         else dtag = "R1";
         chk(rd_data === m_head(), {ptag, " R11 ", dtag, " rd_data"}, rd_data, m_head());
      end
   endtask

   task automatic step(string ptag, bit we, logic [17:0] wd, bit re);
      bit w_ok, r_ok;
      compare(ptag);
      wr_en = we; wr_data = wd; rd_en = re;
      w_ok = we && !m_full();
      r_ok = re && !m_empty();
      if (r_ok) begin
         void'(q.pop_front());
         if (!m_rn) void'(q.pop_front());
      end
      if (w_ok) begin
         if (m_wn) q.push_back(wd[8:0]);
         else if (m_be) begin q.push_back(wd[17:9]); q.push_back(wd[8:0]); end
         else begin q.push_back(wd[8:0]); q.push_back(wd[17:9]); end
      end
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0;
   endtask

   task automatic mreset(bit wn, bit rn, bit be);
      mrst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
      cfg_wr_narrow = wn; cfg_rd_narrow = rn; cfg_big_end = be;
      repeat (3) @(negedge clk);
      mrst_n = 1'b1;
      m_wn = wn; m_rn = rn; m_be = be;
      q.delete();
      chk(empty && !full && !half_full, "R6 reset flags",
          {15'd0, empty, full, half_full}, 18'b100);
   endtask

   task automatic preset();
      prst_n = 1'b0;
      @(negedge clk);
      prst_n = 1'b1;
      q.delete();
   endtask

   initial begin
      @(negedge clk);
      for (int m = 0; m < 8; m++) begin
         mreset(m[0], m[1], m[2]);
         for (int i = 0; i < DEPTH + 2; i++) step("R1", 1'b1, 18'($urandom), 1'b0);
         chk(full == 1'b1, "R1 full after fill", 18'(full), 18'd1);
         for (int i = 0; i < DEPTH + 2; i++) step("R1", 1'b0, '0, 1'b1);
         for (int i = 0; i < 250; i++)
            step("R12", ($urandom % 3) != 0, 18'($urandom), ($urandom % 2) == 0);
      end

      // R2 / R3: wide word read out on a narrow port
      for (int b = 0; b < 2; b++) begin
         mreset(1'b0, 1'b1, b[0]);
         step("R1", 1'b1, {9'h1A5, 9'h03C}, 1'b0);
         chk(rd_data == (b ? 18'h001A5 : 18'h0003C), b ? "R2 first byte" : "R3 first byte",
             rd_data, b ? 18'h001A5 : 18'h0003C);
         step("R1", 1'b0, '0, 1'b1);
         chk(rd_data == (b ? 18'h0003C : 18'h001A5), b ? "R2 second byte" : "R3 second byte",
             rd_data, b ? 18'h0003C : 18'h001A5);
      end

      // R4: bytes packed into a wide read; one byte alone keeps empty high
      for (int b = 0; b < 2; b++) begin
         mreset(1'b1, 1'b0, b[0]);
         step("R1", 1'b1, 18'h000AB, 1'b0);
         chk(empty == 1'b1, "R8 one byte held on wide read", 18'(empty), 18'd1);
         step("R1", 1'b1, 18'h00155, 1'b0);
         chk(rd_data == (b ? {9'h0AB, 9'h155} : {9'h155, 9'h0AB}), "R4 packed word",
             rd_data, b ? {9'h0AB, 9'h155} : {9'h155, 9'h0AB});
      end

      // R9: one free unit with a wide write port stays full
      mreset(1'b0, 1'b1, 1'b1);
      for (int i = 0; i < DEPTH / 2; i++) step("R9", 1'b1, 18'(i * 3 + 1), 1'b0);
      step("R9", 1'b0, '0, 1'b1);
      chk(full == 1'b1, "R9 one unit free", 18'(full), 18'd1);
      step("R9", 1'b1, 18'h3FFFF, 1'b0);
      for (int i = 0; i < DEPTH; i++) step("R9", 1'b0, '0, 1'b1);

      // R5: pins changed after reset have no effect
      mreset(1'b0, 1'b1, 1'b1);
      cfg_wr_narrow = 1'b1; cfg_rd_narrow = 1'b0; cfg_big_end = 1'b0;
      step("R5", 1'b1, {9'h1A5, 9'h03C}, 1'b0);
      chk(rd_data == 18'h001A5, "R5 settings frozen", rd_data, 18'h001A5);

      // R7: partial reset empties, keeps settings
      step("R7", 1'b1, {9'h111, 9'h022}, 1'b0);
      preset();
      chk(empty == 1'b1, "R7 empty after partial reset", 18'(empty), 18'd1);
      step("R7", 1'b1, {9'h0F0, 9'h00F}, 1'b0);
      chk(rd_data == 18'h000F0, "R7 settings kept", rd_data, 18'h000F0);
      step("R7", 1'b0, '0, 1'b1);
      step("R7", 1'b0, '0, 1'b1);
      compare("R7");

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule